// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter with a 12-bit result. Software starts a conversion by driving a start control high and then low. The rising edge clears the sequencer, and any conversion in progress is abandoned. The falling edge launches a new conversion.

A programmable divider derives the converter clock from the system clock. Each conversion first runs a sampling window of four converter clocks. It then spends one converter clock on each result bit. During each bit period it presents a trial code to the external comparator and reads back the comparator decision.

A busy flag stays high for the whole conversion and falls when the result is ready. At that moment the result is split into a high part and a low part, and a one-cycle interrupt request is raised. Software can either poll the flag or wait for the interrupt.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `eoc`, `irq` and `sample_en` are 0, and `result_hi` and `result_lo` are 0.
- R2: A conversion starts only when `start`, sampled on the system clock, goes from 1 to 0 while `enable` is 1. In the cycle after that edge, `eoc` is 1.
- R3: With divider selection `div_sel` = s, the converter clock period is N = 2^s system clocks. A value of 7 behaves as 6, so N = 64. `eoc` stays high for exactly 16·N system clocks.
- R4: `sample_en` is high for exactly the first 4·N cycles of a conversion. While it is high, `trial_code` is 0.
- R5: Bits are decided MSB first. For each bit, the trial code is the bits already kept with the tested bit set. The bit is kept when `cmp_in` is 1 (the input is at or above the trial level) and is cleared otherwise. With an ideal comparator, the result therefore equals the input level.
- R6: `result_hi` holds result bits 11:8 and `result_lo` holds result bits 7:0.
- R7: `irq` is a single-cycle pulse in the first cycle in which `eoc` is low after a completed conversion. The result outputs change only in that cycle.
- R8: A rising edge of `start` during a conversion drives `eoc` low in the next cycle. No `irq` is raised for that conversion, and the result outputs keep their old value.
- R9: While `enable` is 0, `eoc` is held low, toggles of `start` are ignored, no `irq` is raised, and the result outputs do not change.
- R10: `chan_sel` is captured at the launching edge of `start`. `chan_out` keeps that value through the conversion and afterwards, even if `chan_sel` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter module enable |
| start | input | 1 | Software start control |
| div_sel | input | 3 | Converter clock divider selection (divide by 2^div_sel, 7 acts as 6) |
| chan_sel | input | 4 | Requested input channel |
| cmp_in | input | 1 | Comparator decision, 1 when input is at or above trial level |
| trial_code | output | 12 | Trial level driven to the DAC |
| sample_en | output | 1 | High during the sampling window |
| chan_out | output | 4 | Channel captured for the current conversion |
| eoc | output | 1 | High while converting, low when done |
| result_hi | output | 4 | Result bits 11:8 |
| result_lo | output | 8 | Result bits 7:0 |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest case to reach from the ports is an abort that lands at an arbitrary point in a conversion: inside the sampling window, between two bit decisions, or one cycle before completion. In every such case the old result must survive and no interrupt may escape. The stimulus draws the abort cycle at random across the whole conversion length for random divider settings, and then checks that the following launch converts correctly. Disabling the module in the middle of a conversion, and toggling `start` while it is disabled, are added as directed cases. The comparator is modelled in the bench as an ideal compare of a random input level against `trial_code`, so every completed conversion must return that level exactly.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes a single system clock domain.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DECIDE = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_start_det.sv
// Start-control edge detector.
// Registers the software start control and reports a rising edge (abort)
// and a falling edge (launch). Both are masked while the module is disabled.
// The tracking register keeps following start, so no stale edge is
// reported when enable returns.
module sar_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    output logic launch,
    output logic abort
);
    logic start_q;

    // Track the previous start level.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    assign launch = enable &  start_q & ~start;
    assign abort  = enable & ~start_q &  start;
endmodule

// File: rtl/sar_clkdiv.sv
// Converter clock tick generator.
// Produces a one-cycle tick every 2^shift system clocks while run is high.
// The shift is captured from div_sel when clear is pulsed and is clamped
// to MAX_LOG. Clearing restarts the count, so the first tick comes
// exactly one converter period after clear.
module sar_clkdiv #(
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [SEL_W-1:0] shift;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;

    assign span = (CNT_W+1)'(1) << shift;
    assign lim  = span[CNT_W-1:0] - CNT_W'(1);
    assign tick = run && (cnt == lim);

    // Capture the clamped divider selection at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)     shift <= '0;
        else if (clear) shift <= (div_sel > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : div_sel;
    end

    // Count system clocks within one converter period.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (clear || !run)  cnt <= '0;
        else if (tick)           cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/sar_core.sv
// Successive-approximation state machine.
// Runs SAMPLE_CLKS ticks of sampling, then decides RES_W bits MSB first,
// one per tick. It keeps a bit when cmp_in is 1. At the end it loads the
// result, drops the busy flag and pulses done. Abort and disable return it
// to idle without touching the result.
module sar_core
    import sar_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int SAMPLE_CLKS = 4,
    parameter int CHAN_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              launch,
    input  logic              abort,
    input  logic              tick,
    input  logic              cmp_in,
    input  logic [CHAN_W-1:0] chan_sel,
    output logic [RES_W-1:0]  trial_code,
    output logic              sample_en,
    output logic              busy,
    output logic              done,
    output logic              run,
    output logic [RES_W-1:0]  result,
    output logic [CHAN_W-1:0] chan_out
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam int PH_W  = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1;

    sar_state_e       state;
    logic [IDX_W-1:0] bit_idx;
    logic [PH_W-1:0]  phase;
    logic [RES_W-1:0] sar;
    logic [RES_W-1:0] probe;
    logic [RES_W-1:0] next_sar;

    // One-hot mask for the bit under test.
    assign probe = RES_W'(1) << bit_idx;

    // Register value after keeping or clearing the tested bit.
    always_comb begin
        next_sar = sar;
        next_sar[bit_idx] = cmp_in;
    end

    assign trial_code = (state == ST_DECIDE) ? (sar | probe) : sar;
    assign sample_en  = (state == ST_SAMPLE);
    assign run        = (state != ST_IDLE);

    // Sequencer: sampling window, then bit decisions, then completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            phase    <= '0;
            sar      <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
            chan_out <= '0;
        end else begin
            done <= 1'b0;
            if (!enable || abort) begin
                state <= ST_IDLE;
                busy  <= 1'b0;
            end else if (launch) begin
                state    <= ST_SAMPLE;
                busy     <= 1'b1;
                sar      <= '0;
                phase    <= '0;
                bit_idx  <= IDX_W'(RES_W - 1);
                chan_out <= chan_sel;
            end else if (tick) begin
                case (state)
                    ST_SAMPLE: begin
                        if (phase == PH_W'(SAMPLE_CLKS - 1)) state <= ST_DECIDE;
                        else                                 phase <= phase + PH_W'(1);
                    end
                    ST_DECIDE: begin
                        sar <= next_sar;
                        if (bit_idx == '0) begin
                            state  <= ST_IDLE;
                            busy   <= 1'b0;
                            done   <= 1'b1;
                            result <= next_sar;
                        end else begin
                            bit_idx <= bit_idx - IDX_W'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sar_seq.sv
// Top of the conversion sequencer.
// Joins the start edge detector, the converter clock divider and the
// successive-approximation core, and splits the result into high and low
// parts. Assumes the comparator settles within one converter clock.
module sar_seq #(
    parameter int RES_W       = 12,
    parameter int LO_W        = 8,
    parameter int CHAN_W      = 4,
    parameter int SEL_W       = 3,
    parameter int MAX_LOG     = 6,
    parameter int SAMPLE_CLKS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  start,
    input  logic [SEL_W-1:0]      div_sel,
    input  logic [CHAN_W-1:0]     chan_sel,
    input  logic                  cmp_in,
    output logic [RES_W-1:0]      trial_code,
    output logic                  sample_en,
    output logic [CHAN_W-1:0]     chan_out,
    output logic                  eoc,
    output logic [RES_W-LO_W-1:0] result_hi,
    output logic [LO_W-1:0]       result_lo,
    output logic                  irq
);
    localparam int HI_W = RES_W - LO_W;

    logic             launch;
    logic             abort;
    logic             tick;
    logic             run;
    logic [RES_W-1:0] result;

    sar_start_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (start),
        .launch (launch),
        .abort  (abort)
    );

    sar_clkdiv #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .run     (run),
        .div_sel (div_sel),
        .tick    (tick)
    );

    sar_core #(.RES_W(RES_W), .SAMPLE_CLKS(SAMPLE_CLKS), .CHAN_W(CHAN_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .launch     (launch),
        .abort      (abort),
        .tick       (tick),
        .cmp_in     (cmp_in),
        .chan_sel   (chan_sel),
        .trial_code (trial_code),
        .sample_en  (sample_en),
        .busy       (eoc),
        .done       (irq),
        .run        (run),
        .result     (result),
        .chan_out   (chan_out)
    );

    assign result_hi = result[RES_W-1:LO_W];
    assign result_lo = result[LO_W-1:0];

    // Keeps HI_W visible as a derived size for integrators.
    if (HI_W < 1) begin : g_bad_split
        initial $display("sar_seq: LO_W must be smaller than RES_W");
    end
endmodule

// File: rtl/sar_seq_chk.sv
// Property checker for sar_seq, attached with bind.
// It checks only the port-level protocol.
module sar_seq_chk #(
    parameter int RES_W  = 12,
    parameter int LO_W   = 8,
    parameter int CHAN_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  eoc,
    input logic                  irq,
    input logic                  sample_en,
    input logic [RES_W-1:0]      trial_code,
    input logic [CHAN_W-1:0]     chan_out,
    input logic [RES_W-LO_W-1:0] result_hi,
    input logic [LO_W-1:0]       result_lo
);
    // R7: the interrupt only appears with the flag already low.
    assert_irq_with_eoc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !eoc);

    // R7: the interrupt lasts a single cycle.
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: the result changes only in the interrupt cycle.
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable({result_hi, result_lo}));

    // R9: a disabled module shows no conversion in progress.
    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!eoc && !sample_en));

    // R4: no trial level is driven during sampling.
    assert_sample_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (trial_code == '0));

    // R4: sampling happens only inside a conversion.
    assert_sample_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> eoc);

    // R10: the channel stays fixed while the conversion runs.
    assert_chan_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && $past(eoc)) |-> $stable(chan_out));
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .LO_W(LO_W), .CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .eoc        (eoc),
    .irq        (irq),
    .sample_en  (sample_en),
    .trial_code (trial_code),
    .chan_out   (chan_out),
    .result_hi  (result_hi),
    .result_lo  (result_lo)
);

// File: tb/sar_seq_test.sv
// Self-checking bench for sar_seq: an ideal comparator model, random
// conversions, and directed abort, disable and divider corner cases.
module sar_seq_test;
    localparam int RES_W  = 12;
    localparam int LO_W   = 8;
    localparam int CHAN_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  enable;
    logic                  start;
    logic [2:0]            div_sel;
    logic [CHAN_W-1:0]     chan_sel;
    logic                  cmp_in;
    logic [RES_W-1:0]      trial_code;
    logic                  sample_en;
    logic [CHAN_W-1:0]     chan_out;
    logic                  eoc;
    logic [RES_W-LO_W-1:0] result_hi;
    logic [LO_W-1:0]       result_lo;
    logic                  irq;
    logic [RES_W-1:0]      vin;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    // Ideal comparator: 1 when the input level is at or above the trial level.
    assign cmp_in = (vin >= trial_code);

    sar_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .div_sel(div_sel), .chan_sel(chan_sel), .cmp_in(cmp_in),
        .trial_code(trial_code), .sample_en(sample_en), .chan_out(chan_out),
        .eoc(eoc), .result_hi(result_hi), .result_lo(result_lo), .irq(irq)
    );

    function automatic int div_cycles(input int sel);
        return (sel > 6) ? 64 : (1 << sel);
    endfunction

    function automatic int exp_hi(input int v);
        return (v >> LO_W) & ((1 << (RES_W - LO_W)) - 1);
    endfunction

    function automatic int exp_lo(input int v);
        return v & ((1 << LO_W) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    // One full conversion with an ideal comparator and full checking.
    task automatic run_conv(input logic [RES_W-1:0] v, input int sel, input logic [CHAN_W-1:0] ch);
        int n, busy, samp;
        bit zeros;
        n = div_cycles(sel);
        vin = v;
        div_sel = 3'(sel);
        @(negedge clk) start = 1'b1;
        @(negedge clk) begin start = 1'b0; chan_sel = ch; end
        @(negedge clk) chan_sel = ~ch;
        check(eoc == 1'b1, "R2 eoc after launch", int'(eoc), 1);
        busy = 0; samp = 0; zeros = 1'b1;
        while (eoc && busy < 5000) begin
            busy++;
            if (sample_en) begin
                samp++;
                if (trial_code != '0) zeros = 1'b0;
            end
            @(negedge clk);
        end
        check(busy == 16 * n, "R3 conversion length", busy, 16 * n);
        check(samp == 4 * n, "R4 sampling window", samp, 4 * n);
        check(zeros, "R4 trial zero while sampling", int'(zeros), 1);
        check({result_hi, result_lo} == v, "R5 result value", int'({result_hi, result_lo}), int'(v));
        check(result_hi == exp_hi(int'(v)) && result_lo == exp_lo(int'(v)), "R6 result split",
              int'({result_hi, result_lo}), int'(v));
        check(irq == 1'b1, "R7 irq at completion", int'(irq), 1);
        check(chan_out == ch, "R10 latched channel", int'(chan_out), int'(ch));
        @(negedge clk);
        check(irq == 1'b0, "R7 irq single cycle", int'(irq), 0);
    endtask

    // Launch, then abort after `wait_n` cycles; start is left high.
    task automatic abort_conv(input int sel, input int wait_n);
        int n, seen;
        logic [RES_W-1:0] old;
        n = div_cycles(sel);
        old = {result_hi, result_lo};
        vin = RES_W'($urandom);
        div_sel = 3'(sel);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (wait_n) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(eoc == 1'b0, "R8 eoc low after abort", int'(eoc), 0);
        seen = 0;
        repeat (16 * n + 8) begin
            if (irq || eoc) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R8 no irq after abort", seen, 0);
        check({result_hi, result_lo} == old, "R8 result kept", int'({result_hi, result_lo}), int'(old));
    endtask

    initial begin
        int lvl[4];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; enable = 1'b1; start = 1'b0; div_sel = 3'd0;
        chan_sel = '0; vin = '0;
        repeat (3) @(negedge clk);
        check(!eoc && !irq && !sample_en, "R1 flags in reset", int'({eoc, irq, sample_en}), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check({result_hi, result_lo} == '0, "R1 result after reset", int'({result_hi, result_lo}), 0);
        check(!eoc && !irq, "R1 flags after reset", int'({eoc, irq}), 0);

        // Directed levels at the code boundaries.
        lvl[0] = 0; lvl[1] = 4095; lvl[2] = 2048; lvl[3] = 2047;
        foreach (lvl[i]) run_conv(RES_W'(lvl[i]), i, CHAN_W'(i + 3));

        // Selection 7 must behave like 6 (R3).
        run_conv(RES_W'(12'hA5C), 7, 4'd9);

        // Aborts at chosen and random points (R8), each followed by a good conversion.
        abort_conv(0, 1);
        run_conv(RES_W'(12'h123), 0, 4'd1);
        abort_conv(2, 16 * 4 - 2);
        run_conv(RES_W'(12'hFFE), 2, 4'd2);
        for (int k = 0; k < 6; k++) begin
            int s;
            s = int'($urandom_range(0, 4));
            abort_conv(s, int'($urandom_range(1, 16 * div_cycles(s) - 1)));
            run_conv(RES_W'($urandom), s, CHAN_W'($urandom));
        end

        // Disabled: start toggles are ignored (R9).
        begin
            logic [RES_W-1:0] old;
            int seen;
            old = {result_hi, result_lo};
            @(negedge clk) begin enable = 1'b0; start = 1'b0; end
            seen = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk) start = 1'b1;
                if (eoc || irq) seen++;
                @(negedge clk) start = 1'b0;
                repeat (20) begin
                    @(negedge clk);
                    if (eoc || irq) seen++;
                end
            end
            check(seen == 0, "R9 start ignored while disabled", seen, 0);
            check({result_hi, result_lo} == old, "R9 result kept while disabled",
                  int'({result_hi, result_lo}), int'(old));
            // Disable in the middle of a conversion.
            @(negedge clk) enable = 1'b1;
            repeat (2) @(negedge clk);
            div_sel = 3'd1;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (10) @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            check(eoc == 1'b0, "R9 eoc low on disable", int'(eoc), 0);
            seen = 0;
            repeat (40) begin
                @(negedge clk);
                if (irq || eoc) seen++;
            end
            check(seen == 0, "R9 no irq after disable", seen, 0);
            check({result_hi, result_lo} == old, "R9 result kept after disable",
                  int'({result_hi, result_lo}), int'(old));
            @(negedge clk) enable = 1'b1;
            repeat (2) @(negedge clk);
        end

        // Random conversions over all divider settings.
        for (int k = 0; k < 40; k++) begin
            run_conv(RES_W'($urandom), int'($urandom_range(0, 7)), CHAN_W'($urandom));
        end

        finish_run();
    end
endmodule